// File: doc/BRIEF.md
# Dual-Output Sawtooth PWM Timer Channel

This block is a single timer channel that produces two pulse-width modulated outputs, A and B. Both outputs run from one up-counter. The counter advances once per prescaled tick and returns to zero after reaching a shared period value. Each output has its own compare register. An output is high from the start of each cycle and toggles when the counter reaches that output's compare value, so every compare register sets its own duty cycle.

Software uses a small register interface to set the period, the compares, the count direction, the clock prescale, the per-output pin function and the per-output enables, and then starts counting. Mode and prescale are locked while the counter runs. A pin that is disabled, or that has an unsupported function code, is held low. A pin is also held low whenever the channel is not counting.

Top module: `saw_pwm_channel`

## Requirements
- R1: After synchronous reset, every register reads 0 and both outputs are low.
- R2: Registers sit at these byte offsets: control 0x2C, direction 0x30, pin control 0x34, buffer enable 0x40, counter 0x48, compare A 0x4C, compare B 0x50, period 0x64.
  - Control fields: start at bit 0, mode at bits 18:16, clock select at bits 26:24.
  - Direction fields: up bit at bit 0, forced-direction bit at bit 1.
  - Pin control fields: A function at bits 4:0 with A enable at bit 8, and B function at bits 20:16 with B enable at bit 24.
  - Every register reads back what was written. Unused bits read 0. The buffer enable register keeps all 32 bits and has no effect.
- R3: The counter advances by one on each prescaled tick only while start is 1, mode is 0 (sawtooth) and the up bit is 1. Otherwise it holds its value.
- R4: Clock select 0, 1, 2, 3, 4 and 5 gives one tick every 1, 4, 16, 64, 256 and 1024 clocks. Clock select 6 and 7 behave as 1024. The first tick comes that many clocks after the start write.
- R5: On a tick where the counter is at or above the period value, the counter goes to 0 instead of incrementing.
- R6: With function code 0x1B, an output is high when counting starts, and goes high again on every wrap to 0. It toggles on the tick that brings the counter to its compare value. With compare C no greater than the period P, the output is high for C of every P+1 counts. A compare above the period keeps the output high.
- R7: A control write while start is 1 leaves mode and clock select unchanged but still updates start. While start is 0, a control write updates all three fields.
- R8: An output is low when its enable bit is 0, when its function code is not 0x1B, or when the counter is not advancing per R3.
- R9: Outputs A and B share the counter and the period but follow their own compare values independently.
- R10: The counter register is writable while counting. A write takes effect on that edge and wins over a tick on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_a | output | 1 | Pulse output A |
| pwm_b | output | 1 | Pulse output B |

## Verification
The bench goes after these corner cases:
- **Control write while running.** A design that lets mode or clock select change during counting would show a different control readback and a different tick rate.
- **Counter loaded above the period.** A design that wraps only on equality would run on toward overflow instead of returning to 0 on the next tick.
- **Compare above the period, and compares different on A and B.** A design that mixes up the compares, or toggles on stale values, would show the wrong high-cycle counts over two whole periods.
- **Clock-select codes 2, 5 and 7.** A design that decodes the top select codes wrongly would reach the expected count at the wrong time.
- **Pin disabled, unsupported function code, nonzero mode.** A design that leaks the level register to the pin in these cases would show toggling where it must show a steady low.

// File: rtl/saw_pwm_pkg.sv
package saw_pwm_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int PRE_W  = 10;
    localparam int FUNC_W = 5;
    localparam int N_OUT  = 2;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h2C;
    localparam logic [ADDR_W-1:0] OFF_DIR  = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_PIN  = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_BUF  = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_CNT  = 8'h48;
    localparam logic [ADDR_W-1:0] OFF_CMPA = 8'h4C;
    localparam logic [ADDR_W-1:0] OFF_CMPB = 8'h50;
    localparam logic [ADDR_W-1:0] OFF_PER  = 8'h64;

    localparam logic [FUNC_W-1:0] FN_SET_TOGGLE = 5'h1B;
    localparam logic [2:0]        MODE_SAW      = 3'd0;

    typedef struct packed {
        logic       start;
        logic [2:0] mode;
        logic [2:0] csel;
    } ctrl_t;

    typedef struct packed {
        logic [FUNC_W-1:0] func;
        logic              oe;
    } pin_cfg_t;

    // Terminal value of the prescale divider for a clock-select code.
    function automatic logic [PRE_W-1:0] div_last(input logic [2:0] sel);
        case (sel)
            3'd0:    return PRE_W'(0);
            3'd1:    return PRE_W'(3);
            3'd2:    return PRE_W'(15);
            3'd3:    return PRE_W'(63);
            3'd4:    return PRE_W'(255);
            default: return PRE_W'(1023);
        endcase
    endfunction
endpackage

// File: rtl/saw_pwm_regs.sv
module saw_pwm_regs
    import saw_pwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [CNT_W-1:0]            cnt,
    output logic [DATA_W-1:0]           rdata,
    output ctrl_t                       ctrl,
    output logic [1:0]                  dir,
    output pin_cfg_t [N_OUT-1:0]        pin_cfg,
    output logic [N_OUT-1:0][CNT_W-1:0] cmp,
    output logic [CNT_W-1:0]            per
);
    logic [DATA_W-1:0] buf_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            dir     <= '0;
            pin_cfg <= '0;
            cmp     <= '0;
            per     <= '0;
            buf_en  <= '0;
        end else if (we) begin
            case (addr)
                OFF_CTRL: begin
                    ctrl.start <= wdata[0];
                    if (!ctrl.start) begin
                        ctrl.mode <= wdata[18:16];
                        ctrl.csel <= wdata[26:24];
                    end
                end
                OFF_DIR:  dir <= wdata[1:0];
                OFF_PIN: begin
                    pin_cfg[0] <= '{func: wdata[4:0],   oe: wdata[8]};
                    pin_cfg[1] <= '{func: wdata[20:16], oe: wdata[24]};
                end
                OFF_BUF:  buf_en <= wdata;
                OFF_CMPA: cmp[0] <= wdata[CNT_W-1:0];
                OFF_CMPB: cmp[1] <= wdata[CNT_W-1:0];
                OFF_PER:  per    <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFF_CTRL: begin
                rdata[0]     = ctrl.start;
                rdata[18:16] = ctrl.mode;
                rdata[26:24] = ctrl.csel;
            end
            OFF_DIR: rdata[1:0] = dir;
            OFF_PIN: begin
                rdata[4:0]   = pin_cfg[0].func;
                rdata[8]     = pin_cfg[0].oe;
                rdata[20:16] = pin_cfg[1].func;
                rdata[24]    = pin_cfg[1].oe;
            end
            OFF_BUF:  rdata = buf_en;
            OFF_CNT:  rdata = DATA_W'(cnt);
            OFF_CMPA: rdata = DATA_W'(cmp[0]);
            OFF_CMPB: rdata = DATA_W'(cmp[1]);
            OFF_PER:  rdata = DATA_W'(per);
            default: ;
        endcase
    end

    // R7: mode and clock select are frozen across a control write while running
    p_mode_locked_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.start && we && addr == OFF_CTRL) |=> ($stable(ctrl.mode) && $stable(ctrl.csel)));
endmodule

// File: rtl/saw_pwm_prescaler.sv
module saw_pwm_prescaler
    import saw_pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] csel,
    output logic       tick
);
    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] last;

    assign last = div_last(csel);
    assign tick = run && (pre >= last);

    always_ff @(posedge clk) begin
        if (rst || !run) pre <= '0;
        else if (pre >= last) pre <= '0;
        else pre <= pre + 1'b1;
    end

    // R4: the divider restarts from zero whenever counting is off
    p_pre_clear_r4: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pre == '0));
endmodule

// File: rtl/saw_pwm_counter.sv
module saw_pwm_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [CNT_W-1:0] per,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             wrap
);
    assign wrap    = tick && (cnt >= per);
    assign cnt_nxt = wrap ? '0 : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else if (load) cnt <= load_val;
        else if (tick) cnt <= cnt_nxt;
    end

    // R3: no tick and no load keeps the count
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt));
    // R5: a tick at or above the period returns the counter to zero
    p_wrap_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (wrap && !load) |=> (cnt == '0));
endmodule

// File: rtl/saw_pwm_out.sv
module saw_pwm_out
    import saw_pwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] cmp,
    input  pin_cfg_t         cfg,
    output logic             pin
);
    logic lvl;

    always_ff @(posedge clk) begin
        if (rst || !run) lvl <= 1'b1;
        else if (wrap) lvl <= 1'b1;
        else if (tick && cnt_nxt == cmp) lvl <= ~lvl;
    end

    assign pin = run && cfg.oe && (cfg.func == FN_SET_TOGGLE) && lvl;

    // R6: the cycle-end tick always leaves the output level high
    p_end_high_r6: assert property (@(posedge clk) disable iff (rst)
        wrap |=> lvl);
    // R8: while idle the level is preset so counting starts high
    p_idle_preset_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> lvl);
endmodule

// File: rtl/saw_pwm_channel.sv
module saw_pwm_channel
    import saw_pwm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pwm_a,
    output logic              pwm_b
);
    ctrl_t                       ctrl;
    logic [1:0]                  dir;
    pin_cfg_t [N_OUT-1:0]        pin_cfg;
    logic [N_OUT-1:0][CNT_W-1:0] cmp;
    logic [CNT_W-1:0]            per;
    logic [CNT_W-1:0]            cnt;
    logic [CNT_W-1:0]            cnt_nxt;
    logic                        wrap;
    logic                        tick;
    logic                        run;
    logic                        cnt_load;
    logic [N_OUT-1:0]            pin;

    assign run      = ctrl.start && (ctrl.mode == MODE_SAW) && dir[0];
    assign cnt_load = reg_we && (reg_addr == OFF_CNT);

    saw_pwm_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .cnt(cnt), .rdata(reg_rdata), .ctrl(ctrl), .dir(dir),
        .pin_cfg(pin_cfg), .cmp(cmp), .per(per)
    );

    saw_pwm_prescaler pre_i (
        .clk(clk), .rst(rst), .run(run), .csel(ctrl.csel), .tick(tick)
    );

    saw_pwm_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst(rst), .tick(tick), .per(per), .load(cnt_load),
        .load_val(reg_wdata[CNT_W-1:0]), .cnt(cnt), .cnt_nxt(cnt_nxt), .wrap(wrap)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        saw_pwm_out #(.CNT_W(CNT_W)) out_i (
            .clk(clk), .rst(rst), .run(run), .tick(tick), .wrap(wrap),
            .cnt_nxt(cnt_nxt), .cmp(cmp[g]), .cfg(pin_cfg[g]), .pin(pin[g])
        );
    end

    assign pwm_a = pin[0];
    assign pwm_b = pin[1];

    // R8: pins stay low whenever counting is off
    p_pins_low_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!pwm_a && !pwm_b));
endmodule

// File: tb/saw_pwm_channel_tb_top.sv
`timescale 1ns/1ps
module saw_pwm_channel_tb_top;
    import saw_pwm_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        pwm_a, pwm_b;

    always #2.5 clk = ~clk;

    saw_pwm_channel dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic        m_start;
    logic [2:0]  m_mode, m_sel;
    logic [1:0]  m_dir;
    logic [4:0]  m_fa, m_fb;
    logic        m_oa, m_ob, m_la, m_lb;
    logic [31:0] m_buf, m_cnt, m_ca, m_cb, m_per;
    int          m_pre;

    function automatic int m_div(input logic [2:0] s);
        return (s >= 3'd5) ? 1024 : (1 << (2 * int'(s)));
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h2C: return {5'b0, m_sel, 5'b0, m_mode, 15'b0, m_start};
            8'h30: return {30'b0, m_dir};
            8'h34: return {7'b0, m_ob, 3'b0, m_fb, 7'b0, m_oa, 3'b0, m_fa};
            8'h40: return m_buf;
            8'h48: return m_cnt;
            8'h4C: return m_ca;
            8'h50: return m_cb;
            8'h64: return m_per;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic m_act();
        return m_start && m_mode == 3'd0 && m_dir[0];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_start = 0; m_mode = 0; m_sel = 0; m_dir = 0;
            m_fa = 0; m_fb = 0; m_oa = 0; m_ob = 0; m_la = 1; m_lb = 1;
            m_buf = 0; m_cnt = 0; m_ca = 0; m_cb = 0; m_per = 0; m_pre = 0;
        end else begin
            if (m_act()) begin
                if (m_pre == m_div(m_sel) - 1) begin
                    m_pre = 0;
                    if (m_cnt >= m_per) begin
                        m_cnt = 0; m_la = 1; m_lb = 1;
                    end else begin
                        m_cnt = m_cnt + 1;
                        if (m_cnt == m_ca) m_la = !m_la;
                        if (m_cnt == m_cb) m_lb = !m_lb;
                    end
                end else begin
                    m_pre = m_pre + 1;
                end
            end else begin
                m_pre = 0; m_la = 1; m_lb = 1;
            end
            if (reg_we) begin
                case (reg_addr)
                    8'h2C: begin
                        if (!m_start) begin
                            m_mode = reg_wdata[18:16];
                            m_sel  = reg_wdata[26:24];
                        end
                        m_start = reg_wdata[0];
                    end
                    8'h30: m_dir = reg_wdata[1:0];
                    8'h34: begin
                        m_fa = reg_wdata[4:0];   m_oa = reg_wdata[8];
                        m_fb = reg_wdata[20:16]; m_ob = reg_wdata[24];
                    end
                    8'h40: m_buf = reg_wdata;
                    8'h48: m_cnt = reg_wdata;
                    8'h4C: m_ca = reg_wdata;
                    8'h50: m_cb = reg_wdata;
                    8'h64: m_per = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (!rst) begin
            logic ea, eb;
            logic [31:0] er;
            ea = m_act() && m_oa && m_fa == 5'h1B && m_la;
            eb = m_act() && m_ob && m_fb == 5'h1B && m_lb;
            er = m_read(reg_addr);
            n_vec++;
            if (pwm_a !== ea || pwm_b !== eb || reg_rdata !== er) begin
                n_bad++;
                $display("FAIL %s: a/b/rdata got %b/%b/%h expected %b/%b/%h",
                         cur_req, pwm_a, pwm_b, reg_rdata, ea, eb, er);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // all tasks start and end 1 ns after a rising edge
    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 0;
    endtask

    task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #0.5;
        chk(req, reg_rdata, exp);
    endtask

    task automatic count_high(input int n, output int ha, output int hb);
        ha = 0; hb = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_a) ha++;
            if (pwm_b) hb++;
            idle(1);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL all requirements: watchdog expired, got hung expected done");
        finish_run();
    end

    initial begin
        int ha, hb;
        logic [31:0] snap;
        idle(3);
        rst = 0;

        // R1 reset state
        cur_req = "R1";
        foreach (snap[i]) ; // no-op keeps snap used
        chk_rd("R1 ctrl", 8'h2C, 0);
        chk_rd("R1 dir",  8'h30, 0);
        chk_rd("R1 pin",  8'h34, 0);
        chk_rd("R1 buf",  8'h40, 0);
        chk_rd("R1 cnt",  8'h48, 0);
        chk_rd("R1 cmpa", 8'h4C, 0);
        chk_rd("R1 cmpb", 8'h50, 0);
        chk_rd("R1 per",  8'h64, 0);
        chk("R1 pins", {30'b0, pwm_a, pwm_b}, 0);
        idle(1);

        // R2 programming and readback
        cur_req = "R2";
        wr(8'h64, 9);
        wr(8'h4C, 4);
        wr(8'h50, 7);
        wr(8'h34, 32'h011B_011B);
        wr(8'h30, 3);
        wr(8'h40, 32'hA5A5_0F0F);
        wr(8'h2C, 32'h0000_0001);
        chk_rd("R2 ctrl", 8'h2C, 1);
        chk_rd("R2 dir",  8'h30, 3);
        chk_rd("R2 pin",  8'h34, 32'h011B_011B);
        chk_rd("R2 buf",  8'h40, 32'hA5A5_0F0F);
        chk_rd("R2 per",  8'h64, 9);
        chk_rd("R2 cmpb", 8'h50, 7);
        idle(1);

        // R6 / R9 duty over two whole periods of ten counts
        cur_req = "R6";
        count_high(20, ha, hb);
        chk("R6 A high count", ha, 8);
        chk("R9 B high count", hb, 14);

        // R7 lock while running
        cur_req = "R7";
        wr(8'h2C, 32'h0201_0001);
        chk_rd("R7 locked ctrl", 8'h2C, 1);
        idle(1);

        // R10 counter load while running
        cur_req = "R10";
        wr(8'h48, 2);
        chk_rd("R10 loaded", 8'h48, 2);
        idle(1);
        chk_rd("R3 advance", 8'h48, 3);

        // R8 stop drives pins low, R3 counter holds
        cur_req = "R8";
        wr(8'h2C, 0);
        chk("R8 stopped pins", {30'b0, pwm_a, pwm_b}, 0);
        chk_rd("R3 hold a", 8'h48, 4);
        idle(5);
        chk_rd("R3 hold b", 8'h48, 4);

        // R4 prescale
        cur_req = "R4";
        wr(8'h48, 0);
        wr(8'h2C, 32'h0200_0001);
        chk_rd("R7 fields taken when stopped", 8'h2C, 32'h0200_0001);
        idle(48);
        chk_rd("R4 div16", 8'h48, 3);
        wr(8'h2C, 0);
        wr(8'h48, 0);
        wr(8'h2C, 32'h0700_0001);
        idle(3072);
        chk_rd("R4 sel7 div1024", 8'h48, 3);
        wr(8'h2C, 0);
        wr(8'h48, 0);
        wr(8'h2C, 32'h0500_0001);
        idle(2048);
        chk_rd("R4 sel5 div1024", 8'h48, 2);

        // R5 wrap
        cur_req = "R5";
        wr(8'h2C, 0);
        wr(8'h64, 3);
        wr(8'h48, 0);
        wr(8'h2C, 1);
        idle(3);
        chk_rd("R5 at period", 8'h48, 3);
        idle(1);
        chk_rd("R5 wrapped", 8'h48, 0);
        wr(8'h2C, 0);
        wr(8'h48, 10);
        wr(8'h2C, 1);
        idle(1);
        chk_rd("R5 above period wraps", 8'h48, 0);

        // R8 enables and function codes
        cur_req = "R8";
        wr(8'h34, 32'h011B_001B);
        count_high(10, ha, hb);
        chk("R8 A disabled", ha, 0);
        wr(8'h34, 32'h0101_011B);
        count_high(10, ha, hb);
        chk("R8 B bad code", hb, 0);

        // R6 compare above period, R9 independent compare
        cur_req = "R9";
        wr(8'h34, 32'h011B_011B);
        wr(8'h50, 2);
        idle(8);
        count_high(20, ha, hb);
        chk("R6 compare above period", ha, 20);
        chk("R9 B half duty", hb, 10);

        // R3 nonzero mode and cleared up bit hold the counter
        cur_req = "R3";
        wr(8'h2C, 0);
        wr(8'h2C, 32'h0001_0001);
        reg_addr = 8'h48; #0.5; snap = reg_rdata;
        idle(5);
        chk_rd("R3 mode1 holds", 8'h48, snap);
        chk("R8 mode1 pins", {30'b0, pwm_a, pwm_b}, 0);
        wr(8'h2C, 0);
        wr(8'h2C, 1);
        wr(8'h30, 0);
        reg_addr = 8'h48; #0.5; snap = reg_rdata;
        idle(5);
        chk_rd("R3 up bit clear holds", 8'h48, snap);
        idle(2);

        finish_run();
    end
endmodule